// File: doc/BRIEF.md
# Isochronous Channel Receive Filter

This block sits on the receive side of a node that listens to time-slotted isochronous traffic. Packets arrive on a valid/ready stream that marks the start and end of each packet. The first beat of every packet is a header whose low bits name one of 64 channels. The block looks that channel up in a 64-bit subscription bitmap. If the node is subscribed, the header is stripped and the payload beats go to a downstream sink. If it is not, the whole packet is swallowed without a trace.

Isochronous traffic is never acknowledged, so the filter has no response path of any kind. Software fills the bitmap through a small register port that also exposes a saturating count of the packets that were thrown away. For subscribed packets, backpressure from the sink stalls the input. Unsubscribed packets are drained at one beat per cycle whatever the sink is doing.

Top module: `iso_chan_filter`

## Requirements
- R1: After reset, both bitmap words read zero, the drop count reads zero, `outValid` is low, and no packet is considered open.
- R2: The channel number is taken from bits [5:0] of a beat that has `inSop` set; the upper header bits are ignored. The bitmap is split into two register words. Word 0 (`regAddr`=0) holds channels 0..31 and word 1 (`regAddr`=1) holds channels 32..63. Bit i of word k subscribes channel 32k+i.
- R3: For a subscribed channel, the header beat is not forwarded. Every following beat is forwarded unchanged and in order. `outSop` marks the first forwarded beat and `outEop` mirrors `inEop`.
- R4: For an unsubscribed channel, no beat of the packet raises `outValid`, and every beat is taken with `inReady` high even while `outReady` is low.
- R5: The keep/drop choice is made with the bitmap value held before the header's clock edge and is kept until the end beat. A bitmap write in the same cycle as the header, or during the packet, only affects later headers.
- R6: Every header on an unsubscribed channel adds one to a 16-bit drop count, readable at `regAddr`=2 in bits [15:0]. The count stops at 65535.
- R7: A header beat is always taken at once. During the payload of a kept packet, `inReady` equals `outReady`.
- R8: A packet made of a single beat carrying both `inSop` and `inEop` forwards nothing. It still counts as a drop when its channel is unsubscribed.
- R9: A beat that arrives outside any packet without `inSop` is consumed and not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted |
| inData | input | 32 | Input beat data; header channel in [5:0] |
| inSop | input | 1 | First beat of a packet (header) |
| inEop | input | 1 | Last beat of a packet |
| outValid | output | 1 | Forwarded beat valid |
| outReady | input | 1 | Sink can take a beat |
| outData | output | 32 | Forwarded payload word |
| outSop | output | 1 | First forwarded payload beat |
| outEop | output | 1 | Last forwarded payload beat |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0,1 bitmap words, 2 drop count |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |

## Verification
Two events can land in the same cycle: a bitmap write and the header beat it might be expected to govern. The bench forks a header and a register write so that both are driven at the same falling edge. It then judges the outcome from the scoreboard and the drop count: the packet must follow the old bitmap, and the next header on that channel must follow the new one. A second pairing, a write arriving in the middle of a kept packet, is provoked the same way and must leave that packet whole.

// File: rtl/iso_filt_pkg.sv
package iso_filt_pkg;
  typedef struct packed {
    logic fwd;       // present current input beat downstream
    logic firstPay;  // current forwarded beat is the first payload beat
    logic dropInc;   // a header on an unsubscribed channel was consumed
  } filtStrb_t;
endpackage

// File: rtl/iso_filt_ctrl.sv
module iso_filt_ctrl
  import iso_filt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inSop,
  input  logic      inEop,
  input  logic      subBit,
  input  logic      outReady,
  output logic      inReady,
  output filtStrb_t strb
);
  logic inPkt;
  logic keep;
  logic firstQ;
  logic payBeat;
  logic beat;

  assign payBeat = inValid && inPkt && keep && !inSop;
  assign inReady = payBeat ? outReady : 1'b1;
  assign beat    = inValid && inReady;

  always_comb begin
    strb          = '0;
    strb.fwd      = payBeat;
    strb.firstPay = payBeat && firstQ;
    strb.dropInc  = beat && inSop && !subBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt  <= 1'b0;
      keep   <= 1'b0;
      firstQ <= 1'b0;
    end else if (beat) begin
      if (inSop) begin
        inPkt  <= !inEop;
        keep   <= subBit;
        firstQ <= 1'b1;
      end else if (inPkt) begin
        firstQ <= 1'b0;
        if (inEop) inPkt <= 1'b0;
      end
    end
  end

  // R7
  hdr_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSop) |-> inReady);

  // R7
  stall_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inReady) |-> (!outReady && keep && inPkt));

  // R4
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inPkt && !keep) |-> !strb.fwd);
endmodule

// File: rtl/iso_filt_dp.sv
module iso_filt_dp
  import iso_filt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CH_W   = 6,
  parameter int REG_W  = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inEop,
  input  filtStrb_t         strb,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic              subBit,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outSop,
  output logic              outEop,
  output logic [REG_W-1:0]  regRdData
);
  localparam int NUM_CH     = 1 << CH_W;
  localparam int MASK_WORDS = NUM_CH / REG_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CH-1:0] maskQ;
  logic [CNT_W-1:0]  dropCnt;

  for (genvar w = 0; w < MASK_WORDS; w++) begin : g_maskWord
    always_ff @(posedge clk) begin
      if (!rstN)
        maskQ[w*REG_W +: REG_W] <= '0;
      else if (regWrEn && regAddr == ADDR_W'(w))
        maskQ[w*REG_W +: REG_W] <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      dropCnt <= '0;
    else if (strb.dropInc && dropCnt != CNT_MAX)
      dropCnt <= dropCnt + 1'b1;
  end

  assign subBit   = maskQ[inData[CH_W-1:0]];
  assign outValid = strb.fwd;
  assign outData  = inData;
  assign outSop   = strb.firstPay;
  assign outEop   = strb.fwd && inEop;

  always_comb begin
    regRdData = '0;
    for (int w = 0; w < MASK_WORDS; w++)
      if (regAddr == ADDR_W'(w)) regRdData = maskQ[w*REG_W +: REG_W];
    if (regAddr == ADDR_W'(MASK_WORDS)) regRdData[CNT_W-1:0] = dropCnt;
  end

  // R2
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == '0) |=> (maskQ[REG_W-1:0] == $past(regWrData)));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ##1 ((dropCnt == $past(dropCnt)) || (dropCnt == $past(dropCnt) + 1'b1)));

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dropCnt == CNT_MAX) |=> (dropCnt == CNT_MAX));
endmodule

// File: rtl/iso_chan_filter.sv
module iso_chan_filter
  import iso_filt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CH_W   = 6,
  parameter int REG_W  = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSop,
  input  logic              inEop,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outSop,
  output logic              outEop,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData
);
  filtStrb_t strb;
  logic      subBit;

  iso_filt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .subBit(subBit), .outReady(outReady), .inReady(inReady), .strb(strb)
  );

  iso_filt_dp #(
    .DATA_W(DATA_W), .CH_W(CH_W), .REG_W(REG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .inEop(inEop), .strb(strb),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .subBit(subBit), .outValid(outValid), .outData(outData), .outSop(outSop),
    .outEop(outEop), .regRdData(regRdData)
  );
endmodule

// File: tb/sim_iso_chan_filter.sv
module sim_iso_chan_filter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [31:0] inData = '0;
  logic inReady, outValid, outSop, outEop;
  logic outReady = 1'b1;
  logic [31:0] outData, regRdData;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0;

  always #10 clk = ~clk;

  iso_chan_filter u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inSop(inSop), .inEop(inEop), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outSop(outSop), .outEop(outEop), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  int nChk = 0, nBad = 0, waitCnt = 0, stallMode = 0;
  bit done = 1'b0;
  logic [63:0] subMdl = '0;
  logic [25:0] junk = 26'h2a5_1c3;
  logic [7:0] lfsr = 8'h5b;
  logic [33:0] expQ[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    if (a == 2'd0) subMdl[31:0] = d;
    if (a == 2'd1) subMdl[63:32] = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regCheck(input logic [1:0] a, input logic [31:0] e, input string req);
    @(negedge clk); regAddr = a; #2;
    chk(regRdData == e, req, regRdData, e);
  endtask

  task automatic sendPkt(input int ch, input int len, input logic [31:0] base);
    bit keepE = subMdl[ch];
    bit acc;
    for (int b = 0; b <= len; b++) begin
      @(negedge clk);
      inValid = 1'b1; inSop = (b == 0); inEop = (b == len);
      inData = (b == 0) ? {junk, 6'(ch)} : base + 32'(b - 1);
      if (b > 0 && keepE) expQ.push_back({b == 1, b == len, inData});
      while (1) begin
        #8; acc = inReady;
        @(posedge clk);
        if (acc) break;
        waitCnt++;
        @(negedge clk);
      end
    end
    junk = junk + 26'h13579;
    @(negedge clk); inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && expQ.size() != 0; i++) @(negedge clk);
    chk(expQ.size() == 0, "R3 drain", expQ.size(), 0);
  endtask

  // monitor / scoreboard
  initial begin
    logic [33:0] e;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      outReady = (stallMode == 0) ? 1'b1 : (stallMode == 2) ? 1'b0 : lfsr[0];
      #8;
      if (rstN && outValid) begin
        if (expQ.size() == 0) chk(1'b0, "R4 unexpected beat", outData, 0);
        else if (outReady) begin
          e = expQ.pop_front();
          chk({outSop, outEop, outData} == e, "R3 payload", {outSop, outEop, outData}, e);
        end
      end
    end
  end

  // R9 stray beat checker helper
  task automatic strayBeat(input logic [31:0] d);
    @(negedge clk); inValid = 1'b1; inSop = 1'b0; inEop = 1'b0; inData = d; #8;
    chk(inReady && !outValid, "R9 stray beat", {inReady, outValid}, 2'b10);
    @(negedge clk); inValid = 1'b0;
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1 reset state
    chk(outValid == 1'b0, "R1 outValid", outValid, 0);
    regCheck(2'd0, 0, "R1 mask0");
    regCheck(2'd1, 0, "R1 mask1");
    regCheck(2'd2, 0, "R1 count");

    // R2 bitmap layout: channel 3 (word0 bit3), channel 40 (word1 bit8)
    regWrite(2'd0, 32'h0000_0008);
    regWrite(2'd1, 32'h0000_0100);
    regCheck(2'd1, 32'h100, "R2 mask1 readback");
    sendPkt(3, 4, 32'h1000);          // R3 kept
    sendPkt(40, 3, 32'h2000);         // R2 upper word
    sendPkt(41, 3, 32'h3000);         // R4 dropped neighbour
    sendPkt(2, 2, 32'h3100);          // R4 dropped
    drain();
    regCheck(2'd2, 2, "R6 count after two drops");

    // R7 backpressure with random sink stalls
    stallMode = 1;
    sendPkt(3, 8, 32'h4000);
    sendPkt(40, 1, 32'h4100);
    drain();

    // R4 drop drained at full rate while sink fully stalled
    stallMode = 2;
    w0 = waitCnt;
    sendPkt(7, 5, 32'h5000);
    chk(waitCnt == w0, "R4 no stall on drop", waitCnt - w0, 0);
    // R7 kept packet stalls while sink blocked
    fork
      sendPkt(3, 1, 32'h5100);
      begin repeat (4) @(negedge clk); stallMode = 0; end
    join
    chk(waitCnt > w0, "R7 stall on kept payload", waitCnt - w0, 1);
    drain();

    // R8 single-beat packets
    sendPkt(3, 0, 0);
    sendPkt(9, 0, 0);
    drain();
    regCheck(2'd2, 4, "R8 header-only drop counted");

    // R9 stray beats outside any packet
    strayBeat(32'h0000_0003);
    regCheck(2'd2, 4, "R9 stray not counted");

    // R5 write in same cycle as header: old bitmap (ch3 kept) governs
    fork
      sendPkt(3, 2, 32'h6000);
      regWrite(2'd0, 32'h0000_0000);
    join
    drain();
    regCheck(2'd2, 4, "R5 same-cycle write used old bitmap");
    sendPkt(3, 2, 32'h6100);          // now dropped
    regCheck(2'd2, 5, "R5 new bitmap on next header");

    // R5 write in the middle of a kept packet
    regWrite(2'd1, 32'h0000_0100);
    fork
      sendPkt(40, 6, 32'h7000);
      begin repeat (2) @(negedge clk); regWrite(2'd1, 32'h0); end
    join
    drain();
    regCheck(2'd2, 5, "R5 mid-packet write held");

    // R6 saturation
    for (int i = 0; i < 65540; i++) sendPkt(12, 0, 0);
    regCheck(2'd2, 32'h0000_ffff, "R6 saturation");

    drain();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule